// File: doc/BRIEF.md
# Escalating Two-Stage Watchdog Timer

This block is a watchdog for a processor subsystem. Software loads a non-zero timeout into a register. A 16-bit down counter then runs from a slow tick of about 32 kHz, which first passes a programmable power-of-two divider. If software fails to write the timeout again before the count runs out, the block sets an overflow flag, performs a first configurable action and starts a new count. If the count runs out a second time while the flag is still set, the block performs a second configurable action and halts. Each action can be an interrupt, a system management interrupt (SMI), a system reset request, or nothing.

The slow tick enters asynchronously. A flop chain brings it into the system clock domain, where it becomes a one-cycle enable. While the processor reports suspend (suspend-acknowledge low), a power-down bit in the configuration can block that enable. A system reset stops the timer and clears the timeout. The overflow flag, the two action selections and any pending interrupt or SMI survive a system reset, so handler code can see why the system restarted. Only the power-on reset clears them.

Top module: `wdog_escalator`

## Requirements
- R1: Register map on `reg_addr`. Offset 0 holds the 16-bit timeout. Offset 2 holds the configuration: bits [3:0] prescale N, bits [5:4] first action, bits [7:6] second action, bit 8 power-down. Offset 4 holds the status, with the overflow flag in bit 0. Unused bits and all other offsets read 0. Reads are combinational. A write takes effect on the clock edge where `reg_we` is high.
- R2: A non-zero write to the timeout loads the counter with that value, starts it and clears the prescaler phase. A zero write stops the counter, so that no expiry follows. Rewriting the timeout before it runs out prevents any expiry.
- R3: A rising edge of `tick_32k` is seen as a one-cycle enable two system clocks after it is first sampled. The enable is passed when `susp_ack` is 1, or when the power-down bit is 0. It is blocked when `susp_ack` is 0 and the power-down bit is 1.
- R4: With prescale N, the counter steps once per 2^N passed ticks. N is limited to the parameter MAX_SHIFT. A write to the configuration clears the prescaler phase.
- R5: The counter expires on the step that takes it from 1 to 0, so a timeout of V gives V steps. If the overflow flag is clear at expiry, the flag is set, the first action fires and the counter reloads from the timeout register.
- R6: If the overflow flag is already set at expiry, the second action fires and the counter halts. It stays halted until a new non-zero timeout write.
- R7: Action encoding: 00 none, 01 interrupt, 10 SMI, 11 system reset request. `irq` and `smi` stay high until software writes 0 to status bit 0, which also clears the flag. Writing 1 to that bit has no effect. With action 00 only the flag changes. If an expiry falls on the same edge as a clear, the expiry wins.
- R8: A reset action drives `sys_rst_req` high for exactly 16 system clocks.
- R9: While `sys_rst_n` is low, the counter halts and the timeout, prescale and power-down fields clear, and register writes are ignored. The overflow flag, both action fields, `irq` and `smi` keep their values.
- R10: `por_n` low clears every register, the counter, the prescaler and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, synchronous, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| tick_32k | input | 1 | Slow reference tick, asynchronous |
| susp_ack | input | 1 | Suspend acknowledge, 0 while suspended |
| irq | output | 1 | Watchdog interrupt, level |
| smi | output | 1 | Watchdog SMI, level |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
The embedded assertions check the rules that hold on every cycle. The tick enable is always a single cycle. A first expiry always sets the flag and keeps the counter running, and a second expiry always halts it. A zero timeout write and a system reset both leave the counter halted. A pending interrupt persists until a clear is written, and a clear drops both levels. A reset request, once raised, continues into the next cycle. The scenarios show what no single-cycle property can: expiry timing for several prescale values, the full escalation sequence, blocking by the suspend gate, refresh writes that keep the timer from expiring, the exact pulse length, and which state survives each of the two resets. A reference model compares all outputs and the read data on every clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   // action selection, shared by both stages
   typedef enum logic [1:0] {
      ACT_NONE = 2'b00,
      ACT_IRQ  = 2'b01,
      ACT_SMI  = 2'b10,
      ACT_RST  = 2'b11
   } wd_act_e;

   // configuration register layout (decoded by the prescaler and action logic)
   localparam int PRE_W   = 4;
   localparam int PRE_LSB = 0;
   localparam int A1_LSB  = 4;
   localparam int A2_LSB  = 6;
   localparam int PD_BIT  = 8;

   // register offsets
   localparam int OFF_TIMEOUT = 0;
   localparam int OFF_CONFIG  = 2;
   localparam int OFF_STATUS  = 4;

   typedef struct packed {
      logic             pwr_down;
      wd_act_e          act2;
      wd_act_e          act1;
      logic [PRE_W-1:0] pre_sel;
   } wd_cfg_t;

endpackage

// File: rtl/wdog_tick_gate.sv
module wdog_tick_gate #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic por_n,
   input  logic tick_async,
   input  logic susp_ack,
   input  logic pwr_down,
   output logic tick_en
);

   localparam int SH_W = SYNC_STAGES + 1;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("wdog_tick_gate: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // sync chain followed by one delay stage for edge detection
   logic [SH_W-1:0] sh_q;
   logic            raw_edge;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         sh_q <= '0;
      end else begin
         sh_q <= {sh_q[SH_W-2:0], tick_async};
      end
   end

   assign raw_edge = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
   assign tick_en  = raw_edge & (susp_ack | ~pwr_down);

   // R3: the synchronised enable never lasts more than one cycle
   a_r3_single_cycle: assert property (@(posedge clk) disable iff (!por_n)
      raw_edge |=> !raw_edge);

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
   import wdog_pkg::*;
#(
   parameter int MAX_SHIFT = 15
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             srst_n,
   input  logic             clr,
   input  logic             en,
   input  logic [PRE_W-1:0] sel,
   output logic             step
);

   localparam int PC_W    = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;
   localparam int SEL_TOP = (1 << PRE_W) - 1;

   generate
      if (MAX_SHIFT < 1 || MAX_SHIFT > 30) begin : g_bad_shift
         $error("wdog_prescaler: MAX_SHIFT out of range 1..30");
      end
   endgenerate

   logic [PRE_W-1:0] sel_eff;

   // the clamp is only built when the field can name a shift above the limit
   generate
      if (SEL_TOP <= MAX_SHIFT) begin : g_no_clamp
         assign sel_eff = sel;
      end else begin : g_clamp
         assign sel_eff = (sel > PRE_W'(MAX_SHIFT)) ? PRE_W'(MAX_SHIFT) : sel;
      end
   endgenerate

   logic [PC_W:0]   one_hot;
   logic [PC_W-1:0] mask;
   logic [PC_W-1:0] phase_q;

   assign one_hot = (PC_W+1)'(1) << sel_eff;
   assign mask    = PC_W'(one_hot - (PC_W+1)'(1));
   assign step    = en & ((phase_q & mask) == mask);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         phase_q <= '0;
      end else if (!srst_n || clr) begin
         phase_q <= '0;
      end else if (en) begin
         phase_q <= phase_q + PC_W'(1);
      end
   end

   // R4: a step can only come from a passed tick
   a_r4_step_needs_tick: assert property (@(posedge clk) disable iff (!por_n)
      step |-> en);

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             srst_n,
   input  logic             load,
   input  logic             stop,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             step,
   input  logic             ovf_i,
   output logic             expire,
   output logic             running
);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("wdog_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             last_step;

   assign last_step = run_q & step & (cnt_q <= CNT_W'(1));
   assign expire    = srst_n & ~load & ~stop & last_step;
   assign running   = run_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (!srst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load) begin
         cnt_q <= load_val;
         run_q <= 1'b1;
      end else if (stop) begin
         run_q <= 1'b0;
      end else if (run_q && step) begin
         if (cnt_q <= CNT_W'(1)) begin
            if (ovf_i) begin
               run_q <= 1'b0;
            end else begin
               cnt_q <= reload_val;
            end
         end else begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   // R5: first expiry keeps the counter going
   a_r5_reload_runs: assert property (@(posedge clk) disable iff (!por_n)
      (expire && !ovf_i) |=> run_q);

   // R6: second expiry halts the counter
   a_r6_halt: assert property (@(posedge clk) disable iff (!por_n)
      (expire && ovf_i) |=> !run_q);

   // R9: system reset leaves the counter halted
   a_r9_srst_halts: assert property (@(posedge clk) disable iff (!por_n)
      !srst_n |=> !run_q);

   // R2: zero write halts the counter
   a_r2_zero_stops: assert property (@(posedge clk) disable iff (!por_n)
      (stop && srst_n) |=> !run_q);

endmodule

// File: rtl/wdog_action.sv
module wdog_action
   import wdog_pkg::*;
#(
   parameter int RST_CYC = 16
) (
   input  logic    clk,
   input  logic    por_n,
   input  logic    fire,
   input  wd_act_e act1,
   input  wd_act_e act2,
   input  logic    clr_req,
   output logic    ovf,
   output logic    irq,
   output logic    smi,
   output logic    rst_req
);

   localparam int RC_W = $clog2(RST_CYC + 1);

   generate
      if (RST_CYC < 2) begin : g_bad_pulse
         $error("wdog_action: RST_CYC must be at least 2");
      end
   endgenerate

   logic            ovf_q, irq_q, smi_q;
   logic [RC_W-1:0] rc_q;
   wd_act_e         sel;
   logic            clr_eff;

   // stage chosen by the flag as it stands at expiry
   assign sel     = ovf_q ? act2 : act1;
   assign clr_eff = clr_req & ~fire;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         ovf_q <= 1'b0;
         irq_q <= 1'b0;
         smi_q <= 1'b0;
      end else if (fire) begin
         ovf_q <= 1'b1;
         if (sel == ACT_IRQ) irq_q <= 1'b1;
         if (sel == ACT_SMI) smi_q <= 1'b1;
      end else if (clr_eff) begin
         ovf_q <= 1'b0;
         irq_q <= 1'b0;
         smi_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         rc_q <= '0;
      end else if (fire && sel == ACT_RST) begin
         rc_q <= RC_W'(RST_CYC);
      end else if (rc_q != '0) begin
         rc_q <= rc_q - RC_W'(1);
      end
   end

   assign ovf     = ovf_q;
   assign irq     = irq_q;
   assign smi     = smi_q;
   assign rst_req = (rc_q != '0);

   // R5: any expiry leaves the flag set
   a_r5_flag_set: assert property (@(posedge clk) disable iff (!por_n)
      fire |=> ovf_q);

   // R7: levels hold until a clear is written
   a_r7_irq_hold: assert property (@(posedge clk) disable iff (!por_n)
      (irq_q && !clr_req) |=> irq_q);

   a_r7_clear_drops: assert property (@(posedge clk) disable iff (!por_n)
      (clr_req && !fire) |=> (!irq_q && !smi_q && !ovf_q));

   // R8: the request pulse is longer than one cycle
   a_r8_pulse_cont: assert property (@(posedge clk) disable iff (!por_n)
      $rose(rst_req) |=> rst_req);

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
   import wdog_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 3,
   parameter int MAX_SHIFT   = 15,
   parameter int SYNC_STAGES = 2,
   parameter int RST_CYC     = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              tick_32k,
   input  logic              susp_ack,
   output logic              irq,
   output logic              smi,
   output logic              sys_rst_req
);

   localparam int CFG_W = $bits(wd_cfg_t);

   generate
      if (DATA_W < CNT_W || DATA_W < CFG_W) begin : g_bad_data
         $error("wdog_escalator: DATA_W too narrow");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("wdog_escalator: ADDR_W must reach offset 4");
      end
   endgenerate

   logic [CNT_W-1:0] to_q;
   wd_cfg_t          cfg_q;
   logic             wr_to, wr_cfg, wr_stat;
   logic             load, stop, clr_req;
   logic             tick_en, step, expire, running, ovf;

   assign wr_to   = reg_we & sys_rst_n & (reg_addr == ADDR_W'(OFF_TIMEOUT));
   assign wr_cfg  = reg_we & sys_rst_n & (reg_addr == ADDR_W'(OFF_CONFIG));
   assign wr_stat = reg_we & sys_rst_n & (reg_addr == ADDR_W'(OFF_STATUS));
   assign load    = wr_to & (|reg_wdata[CNT_W-1:0]);
   assign stop    = wr_to & ~(|reg_wdata[CNT_W-1:0]);
   assign clr_req = wr_stat & ~reg_wdata[0];

   // timeout and the fields a system reset clears
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         to_q           <= '0;
         cfg_q.pre_sel  <= '0;
         cfg_q.pwr_down <= 1'b0;
      end else if (!sys_rst_n) begin
         to_q           <= '0;
         cfg_q.pre_sel  <= '0;
         cfg_q.pwr_down <= 1'b0;
      end else begin
         if (wr_to) to_q <= reg_wdata[CNT_W-1:0];
         if (wr_cfg) begin
            cfg_q.pre_sel  <= reg_wdata[PRE_LSB +: PRE_W];
            cfg_q.pwr_down <= reg_wdata[PD_BIT];
         end
      end
   end

   // action fields survive system reset
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         cfg_q.act1 <= ACT_NONE;
         cfg_q.act2 <= ACT_NONE;
      end else if (wr_cfg) begin
         cfg_q.act1 <= wd_act_e'(reg_wdata[A1_LSB +: 2]);
         cfg_q.act2 <= wd_act_e'(reg_wdata[A2_LSB +: 2]);
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(OFF_TIMEOUT): reg_rdata[CNT_W-1:0] = to_q;
         ADDR_W'(OFF_CONFIG): begin
            reg_rdata[PRE_LSB +: PRE_W] = cfg_q.pre_sel;
            reg_rdata[A1_LSB +: 2]      = cfg_q.act1;
            reg_rdata[A2_LSB +: 2]      = cfg_q.act2;
            reg_rdata[PD_BIT]           = cfg_q.pwr_down;
         end
         ADDR_W'(OFF_STATUS): reg_rdata[0] = ovf;
         default: reg_rdata = '0;
      endcase
   end

   wdog_tick_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk        (clk),
      .por_n      (por_n),
      .tick_async (tick_32k),
      .susp_ack   (susp_ack),
      .pwr_down   (cfg_q.pwr_down),
      .tick_en    (tick_en)
   );

   wdog_prescaler #(.MAX_SHIFT(MAX_SHIFT)) u_pre (
      .clk    (clk),
      .por_n  (por_n),
      .srst_n (sys_rst_n),
      .clr    (wr_to | wr_cfg),
      .en     (tick_en),
      .sel    (cfg_q.pre_sel),
      .step   (step)
   );

   wdog_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .por_n      (por_n),
      .srst_n     (sys_rst_n),
      .load       (load),
      .stop       (stop),
      .load_val   (reg_wdata[CNT_W-1:0]),
      .reload_val (to_q),
      .step       (step),
      .ovf_i      (ovf),
      .expire     (expire),
      .running    (running)
   );

   wdog_action #(.RST_CYC(RST_CYC)) u_act (
      .clk     (clk),
      .por_n   (por_n),
      .fire    (expire),
      .act1    (cfg_q.act1),
      .act2    (cfg_q.act2),
      .clr_req (clr_req),
      .ovf     (ovf),
      .irq     (irq),
      .smi     (smi),
      .rst_req (sys_rst_req)
   );

   // R9: overflow flag is kept across a system reset
   a_r9_flag_kept: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && ovf) |=> ovf);

   // R1: a written timeout reads back on the next cycle
   a_r1_to_readback: assert property (@(posedge clk) disable iff (!por_n)
      wr_to |=> (to_q == $past(reg_wdata[CNT_W-1:0])));

   // R6: no expiry can come from a halted counter
   a_r6_no_expiry_halted: assert property (@(posedge clk) disable iff (!por_n)
      !running |-> !expire);

endmodule

// File: tb/wdog_escalator_tb_top.sv
module wdog_escalator_tb_top;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        tick_32k = 1'b0;
   logic        susp_ack = 1'b1;
   logic        irq, smi, sys_rst_req;

   int n_chk = 0;
   int n_fail = 0;
   bit cmp_on = 1'b0;

   always #5 clk = ~clk;

   wdog_escalator dut_i (
      .clk         (clk),
      .por_n       (por_n),
      .sys_rst_n   (sys_rst_n),
      .reg_we      (reg_we),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_rdata   (reg_rdata),
      .tick_32k    (tick_32k),
      .susp_ack    (susp_ack),
      .irq         (irq),
      .smi         (smi),
      .sys_rst_req (sys_rst_req)
   );

   // ---------------- reference model ----------------
   int m_to, m_pres, m_a1, m_a2, m_pd, m_ovf, m_run, m_cnt, m_pc;
   int m_irq, m_smi, m_rc;
   int p1, p2, p3;
   int ev, tk, sh, mask, fired, act;
   int q_len;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_to = 0; m_pres = 0; m_a1 = 0; m_a2 = 0; m_pd = 0; m_ovf = 0;
         m_run = 0; m_cnt = 0; m_pc = 0; m_irq = 0; m_smi = 0; m_rc = 0;
         p1 = 0; p2 = 0; p3 = 0;
      end else begin
         ev = (p2 == 1 && p3 == 0) ? 1 : 0;
         p3 = p2; p2 = p1; p1 = int'(tick_32k);
         if (!(susp_ack || m_pd == 0)) ev = 0;
         sh = (m_pres > 15) ? 15 : m_pres;
         mask = (1 << sh) - 1;
         tk = (ev == 1 && (m_pc & mask) == mask) ? 1 : 0;
         fired = 0; act = 0;
         if (m_rc > 0) m_rc = m_rc - 1;
         if (!sys_rst_n) begin
            m_to = 0; m_pres = 0; m_pd = 0; m_run = 0; m_cnt = 0; m_pc = 0;
         end else begin
            if (ev == 1) m_pc = (m_pc + 1) % 32768;
            if (reg_we && reg_addr == 3'd0) begin
               m_to = int'(reg_wdata);
               m_pc = 0;
               if (reg_wdata != 0) begin m_cnt = int'(reg_wdata); m_run = 1; end
               else m_run = 0;
            end else if (m_run == 1 && tk == 1) begin
               if (m_cnt <= 1) begin
                  fired = 1;
                  act = (m_ovf == 1) ? m_a2 : m_a1;
                  if (m_ovf == 1) m_run = 0;
                  else begin m_cnt = m_to; m_ovf = 1; end
               end else m_cnt = m_cnt - 1;
            end
            if (reg_we && reg_addr == 3'd2) begin
               m_pres = int'(reg_wdata[3:0]);
               m_a1 = int'(reg_wdata[5:4]);
               m_a2 = int'(reg_wdata[7:6]);
               m_pd = int'(reg_wdata[8]);
               m_pc = 0;
            end
            if (fired == 0 && reg_we && reg_addr == 3'd4 && !reg_wdata[0]) begin
               m_ovf = 0; m_irq = 0; m_smi = 0;
            end
         end
         if (fired == 1) begin
            if (act == 1) m_irq = 1;
            if (act == 2) m_smi = 1;
            if (act == 3) m_rc = 16;
         end
      end
   end

   function automatic int m_rd(logic [2:0] a);
      case (a)
         3'd0: return m_to;
         3'd2: return m_pres | (m_a1 << 4) | (m_a2 << 6) | (m_pd << 8);
         3'd4: return m_ovf;
         default: return 0;
      endcase
   endfunction

   task automatic chk(string tag, int actual, int expected);
      n_chk++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, actual, expected, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (cmp_on && por_n) begin
         chk("R7 irq vs model", int'(irq), m_irq);
         chk("R7 smi vs model", int'(smi), m_smi);
         chk("R8 sys_rst_req vs model", int'(sys_rst_req), (m_rc != 0) ? 1 : 0);
         chk("R1 rdata vs model", int'(reg_rdata), m_rd(reg_addr));
      end
   end

   // slow tick: edge every 8 system clocks
   initial begin
      forever begin
         repeat (4) @(posedge clk);
         #1 tick_32k = ~tick_32k;
      end
   end

   task automatic wr(logic [2:0] a, logic [15:0] d);
      @(posedge clk); #1;
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(string tag, logic [2:0] a, int expected);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      chk(tag, int'(reg_rdata), expected);
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 por_n = 1'b1;
      cmp_on = 1'b1;
      // R10: power-on state
      @(negedge clk);
      chk("R10 irq after por", int'(irq), 0);
      chk("R10 rst_req after por", int'(sys_rst_req), 0);
      rd_chk("R10 timeout after por", 3'd0, 0);
      rd_chk("R10 config after por", 3'd2, 0);
      rd_chk("R10 status after por", 3'd4, 0);

      // R5 R6: escalation, irq then smi, prescale 0
      wr(3'd2, 16'h0090);
      rd_chk("R1 config readback", 3'd2, 16'h0090);
      wr(3'd0, 16'd3);
      wait_cyc(40);
      chk("R5 first expiry irq", int'(irq), 1);
      chk("R5 first expiry no smi", int'(smi), 0);
      rd_chk("R5 flag set", 3'd4, 1);
      wait_cyc(30);
      chk("R6 second expiry smi", int'(smi), 1);
      // R7: writing 1 has no effect
      wr(3'd4, 16'h0001);
      wait_cyc(2);
      chk("R7 write one keeps irq", int'(irq), 1);
      wr(3'd4, 16'h0000);
      wait_cyc(2);
      chk("R7 clear drops irq", int'(irq), 0);
      chk("R7 clear drops smi", int'(smi), 0);
      wait_cyc(100);
      chk("R6 halted no new irq", int'(irq), 0);
      rd_chk("R6 halted flag stays clear", 3'd4, 0);

      // R4 R8: prescale 2, first action reset, second none
      wr(3'd2, 16'h0032);
      wr(3'd0, 16'd2);
      wait_cyc(40);
      chk("R4 prescale delays expiry", int'(sys_rst_req), 0);
      q_len = 0;
      for (int i = 0; i < 250; i++) begin
         @(negedge clk);
         if (sys_rst_req) q_len++;
      end
      chk("R8 pulse length", q_len, 16);
      chk("R7 none action no irq", int'(irq), 0);
      chk("R7 none action no smi", int'(smi), 0);
      rd_chk("R7 none action flag", 3'd4, 1);
      wr(3'd4, 16'h0000);

      // R3: gated while suspended with power-down
      susp_ack = 1'b0;
      wr(3'd2, 16'h0110);
      wr(3'd0, 16'd2);
      wait_cyc(100);
      chk("R3 blocked tick", int'(irq), 0);
      @(posedge clk); #1 susp_ack = 1'b1;
      wait_cyc(40);
      chk("R3 passed tick", int'(irq), 1);
      wr(3'd4, 16'h0000);

      // R2: refresh and zero write
      wr(3'd2, 16'h0010);
      for (int i = 0; i < 10; i++) begin
         wr(3'd0, 16'd4);
         wait_cyc(19);
      end
      chk("R2 refresh prevents expiry", int'(irq), 0);
      wr(3'd0, 16'd5);
      wait_cyc(20);
      wr(3'd0, 16'd0);
      wait_cyc(100);
      chk("R2 zero write stops", int'(irq), 0);

      // R9: system reset keeps flag, actions, irq
      wr(3'd2, 16'h0091);
      wr(3'd0, 16'd1);
      wait_cyc(30);
      chk("R9 irq before srst", int'(irq), 1);
      @(posedge clk); #1 sys_rst_n = 1'b0;
      @(posedge clk); #1;
      @(posedge clk); #1 sys_rst_n = 1'b1;
      @(negedge clk);
      chk("R9 irq kept", int'(irq), 1);
      rd_chk("R9 flag kept", 3'd4, 1);
      rd_chk("R9 config actions kept", 3'd2, 16'h0090);
      rd_chk("R9 timeout cleared", 3'd0, 0);
      wait_cyc(100);
      chk("R9 timer halted", int'(smi), 0);

      // R10: power-on reset clears everything
      @(posedge clk); #1 por_n = 1'b0;
      @(negedge clk);
      chk("R10 irq cleared", int'(irq), 0);
      chk("R10 status cleared", int'(reg_rdata), 0);
      @(posedge clk); #1 por_n = 1'b1;
      rd_chk("R10 config cleared", 3'd2, 0);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule